// File: doc/BRIEF.md
# Instruction Fetch Address Mapper

This block turns a word-addressed program counter into the place a fetch must go. The word PC is scaled to a byte address. One bit of that byte address picks one of two 16-bit fetch map registers. The picked register then either sends the fetch to local instruction memory or names a segment of unified memory. A fetch aimed at a unified segment that is not fitted raises an illegal-instruction exception instead of a valid fetch.

Both map registers sit behind a small write/read port, so the translation can be changed at run time. The result of a fetch request is registered and appears one cycle after the request. The memories and the fetch itself are outside this block. The set of fitted unified segments is a parameter bit mask, so a data-side translator can be given the same mask.

Top module: `ifetch_map`

## Requirements
- R1: After reset both map registers read back 16'h1000, and `out_valid` and `out_illegal` are low.
- R2: `out_offset` is the request PC shifted left by two bits, with the two low bits zero.
- R3: When bit 17 of the byte address (PC bit 15) is 1, map register 1 is used; otherwise map register 0 is used.
- R4: If bit 12 of the selected map register is 1, `out_imem` is 1, `out_seg` is 0 and the fetch is valid, whatever bits 7:0 hold.
- R5: If bit 12 of the selected map register is 0, `out_imem` is 0 and `out_seg` equals map bits 7:0.
- R6: A unified fetch whose segment has a 0 in `SEG_PRESENT` gives `out_illegal` = 1 and `out_valid` = 0. By default segments 0, 1, 2 and 127 are fitted.
- R7: With `cfg_we` high, `cfg_wdata` is written at the clock edge into map register `cfg_sel` (0 or 1). `cfg_rdata` shows all 16 bits of the register chosen by `cfg_sel`.
- R8: A map write is used by fetches from the next cycle on. A fetch requested on the same edge as the write uses the old value.
- R9: Results appear in the cycle after `fetch_req`. In a cycle after no request, `out_valid` and `out_illegal` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Map register write enable |
| cfg_sel | input | 1 | Map register select for write and read-back |
| cfg_wdata | input | 16 | Map register write data |
| cfg_rdata | output | 16 | Read-back of the selected map register |
| fetch_req | input | 1 | Fetch translation request |
| fetch_pc | input | PC_W | Word program counter |
| out_valid | output | 1 | Translated fetch is valid |
| out_imem | output | 1 | 1: instruction memory, 0: unified memory |
| out_seg | output | 8 | Unified segment number |
| out_offset | output | PC_W+2 | Byte address within the target |
| out_illegal | output | 1 | Illegal-instruction exception for this fetch |

## Verification
PCs are taken from both halves of the address space. This shows that bit 17 of the byte address, and no other bit, steers the choice between the two registers. The maps are loaded with patterns that separate the three outcomes: instruction memory with a junk segment field, a fitted unified segment at both ends of the mask, and an unfitted segment. A write and a fetch on the same edge show whether the old or the new map was used. Idle cycles between requests show that no stale valid or exception is left behind.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  localparam int MAP_W        = 16;
  localparam int SEG_W        = 8;
  localparam int MAP_IMEM_BIT = 12;
  localparam logic [MAP_W-1:0] MAP_RESET = 16'h1000;

  // Decoded fields of one map register.
  typedef struct packed {
    logic             imem;
    logic [SEG_W-1:0] seg;
  } map_field_t;

  // Result of one translated fetch.
  typedef struct packed {
    logic             imem;
    logic [SEG_W-1:0] seg;
    logic             ok;
  } xlate_t;
endpackage

// File: rtl/ifm_rst_sync.sv
module ifm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/ifm_map_regs.sv
module ifm_map_regs
  import ifm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [MAP_W-1:0] cfg_wdata,
  output logic [MAP_W-1:0] cfg_rdata,
  output map_field_t       fld0,
  output map_field_t       fld1
);
  logic [MAP_W-1:0] map_q   [2];
  logic [MAP_W-1:0] map_nxt [2];
  logic [1:0]       map_en;

  for (genvar g = 0; g < 2; g++) begin : g_map
    always_comb begin
      map_en[g]  = cfg_we && (cfg_sel == g[0]);
      map_nxt[g] = map_en[g] ? cfg_wdata : map_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[g] <= MAP_RESET;
      else if (map_en[g]) map_q[g] <= map_nxt[g];
    end
  end

  assign cfg_rdata = cfg_sel ? map_q[1] : map_q[0];

  always_comb begin
    fld0.imem = map_q[0][MAP_IMEM_BIT];
    fld0.seg  = map_q[0][SEG_W-1:0];
    fld1.imem = map_q[1][MAP_IMEM_BIT];
    fld1.seg  = map_q[1][SEG_W-1:0];
  end

  AST_MAP0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (map_q[0] == $past(cfg_wdata))); // R7
  AST_MAP1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (map_q[1] == $past(cfg_wdata))); // R7
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(map_q[0]) && $stable(map_q[1])); // R8
endmodule

// File: rtl/ifm_translate.sv
module ifm_translate
  import ifm_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SEL_BIT = 17,
  parameter logic [(1<<SEG_W)-1:0] SEG_PRESENT = '0,
  localparam int BA_W   = PC_W + 2
) (
  input  logic [PC_W-1:0] pc,
  input  map_field_t      fld0,
  input  map_field_t      fld1,
  output logic [BA_W-1:0] byte_addr,
  output xlate_t          res
);
  map_field_t pick;

  always_comb begin
    byte_addr = {pc, 2'b00};
    pick      = byte_addr[SEL_BIT] ? fld1 : fld0;
    res.imem  = pick.imem;
    res.seg   = pick.imem ? '0 : pick.seg;
    res.ok    = pick.imem || SEG_PRESENT[pick.seg];
  end
endmodule

// File: rtl/ifm_out_stage.sv
module ifm_out_stage
  import ifm_pkg::*;
#(
  parameter int BA_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [BA_W-1:0]  byte_addr,
  input  xlate_t           res,
  output logic             out_valid,
  output logic             out_imem,
  output logic [SEG_W-1:0] out_seg,
  output logic [BA_W-1:0]  out_offset,
  output logic             out_illegal
);
  logic             valid_nxt, illegal_nxt;
  logic             imem_q;
  logic [SEG_W-1:0] seg_q;
  logic [BA_W-1:0]  off_q;
  logic             valid_q, illegal_q;

  always_comb begin
    valid_nxt   = req && res.ok;
    illegal_nxt = req && !res.ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      imem_q    <= 1'b1;
      seg_q     <= '0;
      off_q     <= '0;
    end else begin
      valid_q   <= valid_nxt;
      illegal_q <= illegal_nxt;
      if (req) begin
        imem_q <= res.imem;
        seg_q  <= res.seg;
        off_q  <= byte_addr;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_imem    = imem_q;
  assign out_seg     = seg_q;
  assign out_offset  = off_q;

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out_valid && !out_illegal); // R9
  AST_ILLEGAL_UNIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_imem); // R6
  AST_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_illegal) |-> (out_offset[1:0] == 2'b00)); // R2
  AST_IMEM_SEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imem) |-> (out_seg == '0)); // R4
endmodule

// File: rtl/ifetch_map.sv
module ifetch_map
  import ifm_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SEL_BIT = 17,
  parameter logic [(1<<SEG_W)-1:0] SEG_PRESENT =
    ((1<<SEG_W)'(1) << 127) | (1<<SEG_W)'(7),
  localparam int BA_W   = PC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             fetch_req,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             out_valid,
  output logic             out_imem,
  output logic [7:0]       out_seg,
  output logic [BA_W-1:0]  out_offset,
  output logic             out_illegal
);
  logic            rst_sync_n;
  map_field_t      fld0, fld1;
  logic [BA_W-1:0] byte_addr;
  xlate_t          res;

  ifm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ifm_map_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fld0      (fld0),
    .fld1      (fld1)
  );

  ifm_translate #(
    .PC_W        (PC_W),
    .SEL_BIT     (SEL_BIT),
    .SEG_PRESENT (SEG_PRESENT)
  ) u_xlate (
    .pc        (fetch_pc),
    .fld0      (fld0),
    .fld1      (fld1),
    .byte_addr (byte_addr),
    .res       (res)
  );

  ifm_out_stage #(
    .BA_W (BA_W)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req         (fetch_req),
    .byte_addr   (byte_addr),
    .res         (res),
    .out_valid   (out_valid),
    .out_imem    (out_imem),
    .out_seg     (out_seg),
    .out_offset  (out_offset),
    .out_illegal (out_illegal)
  );
endmodule

// File: tb/ifetch_map_test.sv
module ifetch_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        out_valid, out_imem, out_illegal;
  logic [7:0]  out_seg;
  logic [17:0] out_offset;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl_map [2];

  always #5 clk = ~clk;

  ifetch_map uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_req(fetch_req),
    .fetch_pc(fetch_pc), .out_valid(out_valid), .out_imem(out_imem),
    .out_seg(out_seg), .out_offset(out_offset), .out_illegal(out_illegal)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit fitted(logic [7:0] s);
    return (s == 8'd0) || (s == 8'd1) || (s == 8'd2) || (s == 8'd127);
  endfunction

  task automatic write_map(logic sel, logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl_map[sel] = val;
    check("R7 readback", {16'h0, cfg_rdata}, {16'h0, val});
  endtask

  // One fetch, checked against a model built from the requirements.
  task automatic do_fetch(string tag, logic [15:0] pc);
    logic [15:0] m;
    logic        exp_ok;
    @(negedge clk);
    fetch_req = 1'b1; fetch_pc = pc;
    m = pc[15] ? mdl_map[1] : mdl_map[0];   // R3
    @(negedge clk);
    fetch_req = 1'b0;
    exp_ok = m[12] || fitted(m[7:0]);
    check({tag, " R2 offset"}, {14'h0, out_offset}, {14'h0, pc, 2'b00});
    check({tag, " R4/R5 imem"}, {31'h0, out_imem}, {31'h0, m[12]});
    if (exp_ok)
      check({tag, " R5 seg"}, {24'h0, out_seg}, {24'h0, (m[12] ? 8'h00 : m[7:0])});
    check({tag, " R6 valid"}, {31'h0, out_valid}, {31'h0, exp_ok});
    check({tag, " R6 illegal"}, {31'h0, out_illegal}, {31'h0, !exp_ok});
  endtask

  task automatic t_reset;
    cfg_sel = 1'b0; #1;
    check("R1 map0", {16'h0, cfg_rdata}, 32'h1000);
    cfg_sel = 1'b1; #1;
    check("R1 map1", {16'h0, cfg_rdata}, 32'h1000);
    check("R1 valid", {31'h0, out_valid}, 32'h0);
    check("R1 illegal", {31'h0, out_illegal}, 32'h0);
  endtask

  task automatic t_default_imem;
    do_fetch("R4 low half", 16'h0005);
    do_fetch("R3 high half", 16'h8003);
  endtask

  task automatic t_unified;
    write_map(1'b0, 16'h0002);
    do_fetch("R5 seg2", 16'h0010);
    write_map(1'b1, 16'h007F);
    do_fetch("R3 seg127", 16'h8001);
    do_fetch("R3 map0 still", 16'h7FFF);
  endtask

  task automatic t_illegal;
    write_map(1'b0, 16'h0005);
    do_fetch("R6 unfitted", 16'h0020);
    write_map(1'b0, 16'h1005);
    do_fetch("R4 override", 16'h0020);
  endtask

  task automatic t_idle;
    write_map(1'b0, 16'h0003);
    do_fetch("R6 seg3", 16'h0001);
    @(negedge clk);
    check("R9 idle valid", {31'h0, out_valid}, 32'h0);
    check("R9 idle illegal", {31'h0, out_illegal}, 32'h0);
  endtask

  task automatic t_same_edge;
    write_map(1'b0, 16'h1000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0001;
    fetch_req = 1'b1; fetch_pc = 16'h0004;
    @(negedge clk);
    cfg_we = 1'b0; fetch_req = 1'b0;
    check("R8 old map imem", {31'h0, out_imem}, 32'h1);
    check("R8 old map valid", {31'h0, out_valid}, 32'h1);
    mdl_map[0] = 16'h0001;
    do_fetch("R8 new map", 16'h0004);
  endtask

  task automatic t_readback_bits;
    write_map(1'b1, 16'hEFFF);
    write_map(1'b1, 16'h2A55);
    cfg_sel = 1'b0; #1;
    check("R7 sel0 view", {16'h0, cfg_rdata}, {16'h0, mdl_map[0]});
  endtask

  initial begin
    mdl_map[0] = 16'h1000;
    mdl_map[1] = 16'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_default_imem();
    t_unified();
    t_illegal();
    t_idle();
    t_same_edge();
    t_readback_bits();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule